// File: doc/BRIEF.md
# Low-Power Wake Exit Sequencer

This block sits between the power-management controls of a small processor core and the core itself. While the core runs, software can request entry into one of three low-power modes: an idle mode that keeps the primary clock running, an idle mode on a secondary clock, or full sleep. The block then holds the core halted and waits for a wake trigger. Only three triggers count: an interrupt flag whose individual enable is set, a reset request, or a watchdog time-out.

When a trigger arrives, the sequencer latches its cause. It then decides whether the oscillator needs a start-up wait. That wait applies only to crystal-type primary clocks, and never to the idle mode whose primary clock was never stopped. A fixed CPU-preparation delay always follows. The block then releases the core with a one-cycle strobe. A reset wake gives a restart-at-address-zero strobe. Any other wake gives a resume strobe, so the core executes the instruction that follows the sleep instruction. For an interrupt wake, a vector flag beside the resume strobe tells the core whether to branch to the interrupt vector afterwards.

All pins are plain control and status levels or strobes. There is no data stream and therefore no back-pressure.

Top module: `pm_wake_seq`

## Requirements
- R1: After reset, cur_mode is 0 (run), and core_halted, osc_wait, resume_stb, restart_stb and vector_take are all 0.
- R2: In run mode, a cycle with enter_req high and enter_mode non-zero (1 = primary-clock idle, 2 = secondary-clock idle, 3 = sleep) raises core_halted and shows the requested mode on cur_mode from the next cycle. A request with enter_mode 0 has no effect.
- R3: In a low-power mode, only irq_flag with irq_en, rst_req, or wdt_tmo starts a wake. irq_flag without irq_en leaves the core halted.
- R4: When rst_req is among the wake triggers of the wake cycle, it wins over every other trigger. The release then pulses restart_stb only, with resume_stb and vector_take low.
- R5: An enabled-interrupt wake without a reset releases with resume_stb. vector_take equals the gie value sampled in the wake cycle.
- R6: A watchdog wake with no other trigger releases with resume_stb and vector_take 0.
- R7: The oscillator start-up wait of OST_CYC cycles applies when clk_kind is 0 to 3 (crystal types) and the mode is not 1. osc_wait is high throughout that wait.
- R8: The preparation delay of PREP_CYC cycles always applies. With the wake trigger sampled at clock edge E0, the release strobe becomes visible just after edge E0+PREP_CYC, plus OST_CYC when R7 applies. For clk_kind 4 to 7, or for mode 1, osc_wait stays 0.
- R9: A release strobe lasts exactly one cycle. In the same cycle cur_mode returns to 0 and core_halted drops, and resume_stb and restart_stb are never high together.
- R10: In run mode, irq_flag, rst_req and wdt_tmo do not produce any strobe and do not halt the core.
- R11: Once a wake has started, further triggers before the release do not change its cause or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enter_req | input | 1 | Request entry into the mode on enter_mode |
| enter_mode | input | 2 | Requested mode: 1 primary idle, 2 secondary idle, 3 sleep |
| clk_kind | input | 3 | Primary clock type: 0-3 crystal types, 4-7 RC/external/internal |
| irq_flag | input | 1 | Interrupt flag level |
| irq_en | input | 1 | Individual enable for that interrupt |
| gie | input | 1 | Global interrupt enable |
| rst_req | input | 1 | Reset wake request |
| wdt_tmo | input | 1 | Watchdog time-out event |
| cur_mode | output | 2 | Current mode, 0 = run |
| core_halted | output | 1 | Core held stopped |
| osc_wait | output | 1 | Oscillator start-up wait in progress |
| resume_stb | output | 1 | One-cycle release: continue after the sleep instruction |
| restart_stb | output | 1 | One-cycle release: restart at address zero |
| vector_take | output | 1 | With resume_stb: branch to the interrupt vector |

## Verification
The main collision is a reset request and an enabled interrupt, or a watchdog time-out, landing in the same wake cycle. The reset priority and the irq-versus-watchdog ordering must then decide the release strobe and the vector flag. Directed trials drive these together with gie high, and random trials draw each trigger independently, so that coincidences arise often. A bench function ranks the triggers by priority, and its outcome is compared with which strobe fires, with vector_take, and with the release cycle. A second overlap is a reset arriving during the start-up wait after an interrupt wake. The bench judges it by checking that the resume strobe arrives unchanged and on time.

// File: rtl/pm_wake_pkg.sv
package pm_wake_pkg;
  typedef enum logic [1:0] {
    PM_RUN      = 2'd0,
    PM_IDLE_PRI = 2'd1,
    PM_IDLE_SEC = 2'd2,
    PM_SLEEP    = 2'd3
  } pm_mode_e;

  typedef enum logic [1:0] {
    WK_NONE  = 2'd0,
    WK_RESET = 2'd1,
    WK_IRQ   = 2'd2,
    WK_WDT   = 2'd3
  } wake_cause_e;

  typedef enum logic [1:0] {
    SQ_RUN  = 2'd0,
    SQ_LOW  = 2'd1,
    SQ_OST  = 2'd2,
    SQ_PREP = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pm_wake_arb.sv
module pm_wake_arb
  import pm_wake_pkg::*;
(
  input  logic        irq_flag,
  input  logic        irq_en,
  input  logic        gie,
  input  logic        rst_req,
  input  logic        wdt_tmo,
  output wake_cause_e cause,
  output logic        vec
);
  // R4: reset outranks interrupt, interrupt outranks watchdog
  always_comb begin
    cause = WK_NONE;
    vec   = 1'b0;
    if (rst_req) begin
      cause = WK_RESET;
    end else if (irq_flag && irq_en) begin
      cause = WK_IRQ;
      vec   = gie;
    end else if (wdt_tmo) begin
      cause = WK_WDT;
    end
  end
endmodule

// File: rtl/pm_ost_policy.sv
module pm_ost_policy
  import pm_wake_pkg::*;
(
  input  pm_mode_e    mode,
  input  logic [2:0]  clk_kind,
  output logic        need_ost
);
  logic crystal;

  always_comb begin
    case (clk_kind)
      3'd0, 3'd1, 3'd2, 3'd3: crystal = 1'b1;
      default:                crystal = 1'b0;
    endcase
  end

  // R7/R8: primary-clock idle never stopped its oscillator
  assign need_ost = crystal && (mode != PM_IDLE_PRI);
endmodule

// File: rtl/pm_delay_cnt.sv
module pm_delay_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= ld_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  a_r8_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(ld_val)));

  a_r8_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/pm_wake_seq.sv
module pm_wake_seq
  import pm_wake_pkg::*;
#(
  parameter int OST_CYC  = 1024,
  parameter int PREP_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_req,
  input  logic [1:0] enter_mode,
  input  logic [2:0] clk_kind,
  input  logic       irq_flag,
  input  logic       irq_en,
  input  logic       gie,
  input  logic       rst_req,
  input  logic       wdt_tmo,
  output logic [1:0] cur_mode,
  output logic       core_halted,
  output logic       osc_wait,
  output logic       resume_stb,
  output logic       restart_stb,
  output logic       vector_take
);
  localparam int MAXC = (OST_CYC > PREP_CYC) ? OST_CYC : PREP_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] OST_LD  = CW'(OST_CYC - 1);
  localparam logic [CW-1:0] PREP_LD = CW'(PREP_CYC - 1);

  seq_state_e  st;
  pm_mode_e    mode;
  wake_cause_e cause, cause_q;
  logic        vec, vec_q, need_ost, cnt_zero, cnt_load;
  logic [CW-1:0] cnt_ld_val;

  pm_wake_arb u_arb (
    .irq_flag (irq_flag),
    .irq_en   (irq_en),
    .gie      (gie),
    .rst_req  (rst_req),
    .wdt_tmo  (wdt_tmo),
    .cause    (cause),
    .vec      (vec)
  );

  pm_ost_policy u_pol (
    .mode     (mode),
    .clk_kind (clk_kind),
    .need_ost (need_ost)
  );

  assign cnt_load   = ((st == SQ_LOW) && (cause != WK_NONE)) ||
                      ((st == SQ_OST) && cnt_zero);
  assign cnt_ld_val = ((st == SQ_LOW) && need_ost) ? OST_LD : PREP_LD;

  pm_delay_cnt #(.W(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (cnt_load),
    .ld_val (cnt_ld_val),
    .zero   (cnt_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= SQ_RUN;
      mode        <= PM_RUN;
      cause_q     <= WK_NONE;
      vec_q       <= 1'b0;
      resume_stb  <= 1'b0;
      restart_stb <= 1'b0;
      vector_take <= 1'b0;
    end else begin
      resume_stb  <= 1'b0;
      restart_stb <= 1'b0;
      vector_take <= 1'b0;
      unique case (st)
        SQ_RUN: begin
          if (enter_req && (pm_mode_e'(enter_mode) != PM_RUN)) begin
            st   <= SQ_LOW;
            mode <= pm_mode_e'(enter_mode);
          end
        end
        SQ_LOW: begin
          if (cause != WK_NONE) begin
            cause_q <= cause;
            vec_q   <= vec;
            st      <= need_ost ? SQ_OST : SQ_PREP;
          end
        end
        SQ_OST: begin
          if (cnt_zero) st <= SQ_PREP;
        end
        SQ_PREP: begin
          if (cnt_zero) begin
            st          <= SQ_RUN;
            mode        <= PM_RUN;
            restart_stb <= (cause_q == WK_RESET);
            resume_stb  <= (cause_q != WK_RESET);
            vector_take <= (cause_q == WK_IRQ) && vec_q;
          end
        end
      endcase
    end
  end

  assign cur_mode    = mode;
  assign core_halted = (st != SQ_RUN);
  assign osc_wait    = (st == SQ_OST);

  a_r9_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(resume_stb && restart_stb));

  a_r5_vector_needs_resume: assert property (@(posedge clk) disable iff (!rst_n)
    vector_take |-> resume_stb);

  a_r10_run_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_RUN) |=> !(resume_stb || restart_stb));

  a_r7_no_ost_pri_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_OST) |-> (mode != PM_IDLE_PRI));

  a_r4_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_LOW && rst_req) |=> (cause_q == WK_RESET));

  a_r3_hold_without_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_LOW && !rst_req && !wdt_tmo && !(irq_flag && irq_en)) |=> (st == SQ_LOW));

  a_r9_release_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_stb || restart_stb) |-> (st == SQ_RUN && mode == PM_RUN));
endmodule

// File: tb/tb_pm_wake_seq.sv
module tb_pm_wake_seq;
  localparam int OST  = 24;
  localparam int PREP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enter_req = 1'b0;
  logic [1:0] enter_mode = 2'd0;
  logic [2:0] clk_kind = 3'd0;
  logic irq_flag = 1'b0, irq_en = 1'b0, gie = 1'b0, rst_req = 1'b0, wdt_tmo = 1'b0;
  logic [1:0] cur_mode;
  logic core_halted, osc_wait, resume_stb, restart_stb, vector_take;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pm_wake_seq #(.OST_CYC(OST), .PREP_CYC(PREP)) dut (
    .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .enter_mode(enter_mode),
    .clk_kind(clk_kind), .irq_flag(irq_flag), .irq_en(irq_en), .gie(gie),
    .rst_req(rst_req), .wdt_tmo(wdt_tmo), .cur_mode(cur_mode),
    .core_halted(core_halted), .osc_wait(osc_wait), .resume_stb(resume_stb),
    .restart_stb(restart_stb), .vector_take(vector_take)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 0 none, 1 reset, 2 irq, 3 wdt
  function automatic int exp_cause(input bit f, e, r, w);
    if (r) return 1;
    if (f && e) return 2;
    if (w) return 3;
    return 0;
  endfunction

  function automatic bit exp_ost(input logic [1:0] m, input logic [2:0] k);
    return (m != 2'd1) && (k < 3'd4);
  endfunction

  task automatic clear_wake();
    irq_flag = 0; irq_en = 0; gie = 0; rst_req = 0; wdt_tmo = 0;
  endtask

  task automatic trial(input logic [1:0] m, input logic [2:0] k,
                       input bit f, e, g, r, w, input bit inject);
    int c, d, n;
    bit ost;
    @(negedge clk);
    enter_req = 1; enter_mode = m; clk_kind = k;
    @(negedge clk);
    enter_req = 0;
    chk(core_halted && cur_mode == m, "R2 enter", {core_halted, cur_mode}, {1'b1, m});
    irq_flag = f; irq_en = e; gie = g; rst_req = r; wdt_tmo = w;
    c = exp_cause(f, e, r, w);
    @(negedge clk);
    clear_wake();
    if (c == 0) begin
      repeat (3) @(negedge clk);
      chk(core_halted && !resume_stb && !restart_stb, "R3 no trigger", core_halted, 1);
      wdt_tmo = 1; g = 0;
      c = 3;
      @(negedge clk);
      clear_wake();
    end
    ost = exp_ost(m, k);
    d = (ost ? OST : 0) + PREP;
    chk(osc_wait == ost, ost ? "R7 osc wait" : "R8 osc skip", osc_wait, ost);
    if (inject) rst_req = 1;
    n = 1;
    while (!(resume_stb || restart_stb) && n < 200) begin
      @(negedge clk);
      rst_req = 0;
      n++;
    end
    chk(n == d + 1, inject ? "R11 timing" : "R8 delay", n, d + 1);
    if (c == 1) begin
      chk(restart_stb && !resume_stb && !vector_take, "R4 reset wake",
          {restart_stb, resume_stb, vector_take}, 3'b100);
    end else if (c == 2) begin
      chk(resume_stb && !restart_stb && vector_take == g,
          inject ? "R11 cause" : "R5 irq wake",
          {restart_stb, resume_stb, vector_take}, {2'b01, g});
    end else begin
      chk(resume_stb && !restart_stb && !vector_take, "R6 wdt wake",
          {restart_stb, resume_stb, vector_take}, 3'b010);
    end
    chk(cur_mode == 0 && !core_halted, "R9 back to run", {core_halted, cur_mode}, 0);
    @(negedge clk);
    chk(!resume_stb && !restart_stb, "R9 one cycle", {resume_stb, restart_stb}, 0);
  endtask

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    chk(cur_mode == 0 && !core_halted && !osc_wait && !resume_stb && !restart_stb && !vector_take,
        "R1 reset state", {cur_mode, core_halted, osc_wait, resume_stb, restart_stb, vector_take}, 0);
    rst_n = 1;
    @(negedge clk);

    // R10: triggers in run mode
    irq_flag = 1; irq_en = 1; gie = 1; rst_req = 1; wdt_tmo = 1;
    @(negedge clk);
    clear_wake();
    repeat (3) begin
      @(negedge clk);
      chk(!core_halted && !resume_stb && !restart_stb, "R10 run ignores wake",
          {core_halted, resume_stb, restart_stb}, 0);
    end

    // R2: enter with mode 0 ignored
    enter_req = 1; enter_mode = 0;
    @(negedge clk);
    enter_req = 0;
    @(negedge clk);
    chk(!core_halted && cur_mode == 0, "R2 mode0 ignored", core_halted, 0);

    // directed corners
    trial(2'd3, 3'd2, 1, 1, 1, 1, 0, 0); // R4 reset with irq together
    trial(2'd2, 3'd5, 1, 1, 1, 0, 1, 0); // R5 irq beats wdt, vector
    trial(2'd1, 3'd0, 1, 1, 0, 0, 0, 0); // R8 primary idle skips OST
    trial(2'd3, 3'd3, 0, 0, 0, 0, 1, 0); // R7 sleep crystal
    trial(2'd3, 3'd6, 1, 0, 1, 0, 0, 0); // R3 flag without enable
    trial(2'd2, 3'd1, 1, 1, 1, 0, 0, 1); // R11 reset during OST

    for (int i = 0; i < 60; i++) begin
      trial(2'($urandom_range(1, 3)), 3'($urandom_range(0, 7)),
            1'($urandom), 1'($urandom), 1'($urandom),
            ($urandom_range(0, 3) == 0), 1'($urandom), ($urandom_range(0, 5) == 0));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule